// File: doc/BRIEF.md
# Second-Operand Shifter with Rotated Immediates

This combinational block forms the second ALU operand and the shifter carry for a data-processing datapath. A single select bit chooses between two readings of a 12-bit operand field. In the immediate reading, the field holds an 8-bit constant and a 4-bit rotate count. The constant is rotated right by twice that count, so a 32-bit constant can be built from a short field. In the register reading, the already-fetched register value is shifted left, shifted right logically or arithmetically, rotated, or rotated through the carry by one place. The shift amount comes either from a 5-bit field or from the low byte of a second register value.

The block holds no state. It decodes the field encodings in which an amount of zero has a special meaning, and it returns the last bit shifted out as the new carry. When no bit leaves the word, it returns the incoming carry flag. Register reads and the extra cycle a register-held amount may cost in a pipeline are handled outside this block.

Top module: `op2_shifter`

## Requirements
- R1: With `imm_sel`=1, `operand_out` is the zero-extended value of `op2_field[7:0]` rotated right by 2×`op2_field[11:8]` places (rotate 13 on 0x40 gives 0x00001000; rotate 8 on 0xFF gives 0x00FF0000). `rm_val` and `rs_val` have no effect.
- R2: With `imm_sel`=1, `carry_out` equals `carry_in` when `op2_field[11:8]` is 0, and equals `operand_out[31]` otherwise.
- R3: With `imm_sel`=0, the field is read as follows. Bits [6:5] select the type: 00 shift left, 01 logical right, 10 arithmetic right, 11 rotate right. Bit 4 selects the amount source: 0 takes `op2_field[11:7]`, 1 takes `rs_val[7:0]`. The shifted value is always `rm_val`. `op2_field[3:0]` has no effect. When bit 4 is 1, `op2_field[11:7]` and `rs_val[31:8]` also have no effect.
- R4: A left shift by n = 1..31 fills with zeros, and the carry is bit 32−n of the input. A left shift with a field amount of 0 passes `rm_val` unchanged, and the carry is `carry_in`.
- R5: A logical right shift by n = 1..31 fills with zeros. An arithmetic right shift by n = 1..31 fills with copies of bit 31. In both cases the carry is bit n−1 of the input.
- R6: A logical or arithmetic right shift with a field amount of 0 acts as a shift by 32. The logical form gives 0 and the arithmetic form gives 32 copies of bit 31. In both cases the carry is input bit 31.
- R7: A rotate with a field amount of 0 is a one-place rotate through carry: the result is {`carry_in`, `rm_val[31:1]`} and the carry is `rm_val[0]`.
- R8: A rotate by n = 1..31 moves the bits leaving bit 0 into bit 31, and the carry is result bit 31.
- R9: With a register-held amount of 0, every type passes `rm_val` unchanged, and the carry is `carry_in`.
- R10: With a register-held amount of exactly 32: a left shift gives 0 with carry `rm_val[0]`; a logical right shift gives 0 with carry `rm_val[31]`. With an amount above 32, both of these give 0 with carry 0. An arithmetic right shift by 32 or more gives 32 copies of bit 31, with carry bit 31.
- R11: A register-held rotate amount of 32 or more rotates by the amount modulo 32. A nonzero multiple of 32 returns `rm_val` unchanged, with carry `rm_val[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op2_field | input | 12 | Operand field, read as rotate count plus constant, or as amount, type, source select and register index |
| imm_sel | input | 1 | 1 selects the rotated-immediate reading |
| rm_val | input | 32 | Value to be shifted in the register reading |
| rs_val | input | 32 | Register whose low byte supplies a register-held amount |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry |

## Verification
The immediate rotator and the register shifter both evaluate the same field on every cycle, and only `imm_sel` decides which result reaches the ports. A swapped or leaking path would therefore look plausible for many inputs. The immediate sweep drives busy, changing register values alongside every constant. The register-amount sweep fills the field bits that would encode an immediate or a field amount with junk. Each result is compared with a bit-serial model computed in the bench, so any contribution from the unselected path shows up as a value or carry mismatch.

// File: rtl/op2_pkg.sv
`timescale 1ns/1ps
package op2_pkg;
    localparam int OPW      = 32;
    localparam int FLD_W    = 12;
    localparam int IMM_W    = 8;
    localparam int ROT_W    = FLD_W - IMM_W;
    localparam int SHF_W    = 5;
    localparam int RAMT_W   = 8;
    localparam int IDX_W    = $clog2(OPW);
    localparam int AMT_LSB  = FLD_W - SHF_W;
    localparam int TYP_LSB  = AMT_LSB - 2;
    localparam int RSEL_BIT = TYP_LSB - 1;

    typedef enum logic [1:0] {
        TY_LSL = 2'b00,
        TY_LSR = 2'b01,
        TY_ASR = 2'b10,
        TY_ROR = 2'b11
    } shift_type_e;

    typedef enum logic [2:0] {
        K_PASS,
        K_LSL,
        K_LSR,
        K_ASR,
        K_ROR,
        K_RRX
    } shift_kind_e;

    typedef struct packed {
        shift_kind_e         kind;
        logic [RAMT_W-1:0]   amt;
    } shift_req_t;

    typedef struct packed {
        logic [OPW-1:0] value;
        logic           carry;
    } shift_res_t;

    function automatic shift_kind_e kind_of(input shift_type_e t);
        case (t)
            TY_LSL:  return K_LSL;
            TY_LSR:  return K_LSR;
            TY_ASR:  return K_ASR;
            default: return K_ROR;
        endcase
    endfunction
endpackage

// File: rtl/op2_decode.sv
`timescale 1ns/1ps
module op2_decode
    import op2_pkg::*;
(
    input  logic [FLD_W-1:0] field_i,
    input  logic [OPW-1:0]   rs_i,
    output shift_req_t       req_o
);
    logic [SHF_W-1:0]  famt;
    shift_type_e       ty;
    logic              rsel;
    logic [RAMT_W-1:0] ramt;
    logic              unused_dec;

    assign famt       = field_i[FLD_W-1:AMT_LSB];
    assign ty         = shift_type_e'(field_i[AMT_LSB-1:TYP_LSB]);
    assign rsel       = field_i[RSEL_BIT];
    assign ramt       = rs_i[RAMT_W-1:0];
    assign unused_dec = ^{field_i[RSEL_BIT-1:0], rs_i[OPW-1:RAMT_W]};

    // Field amount zero carries special meanings; register amount zero never does.
    always_comb begin
        req_o.kind = kind_of(ty);
        req_o.amt  = RAMT_W'(famt);
        if (rsel) begin
            req_o.amt = ramt;
            if (ramt == '0) req_o.kind = K_PASS;
        end else if (famt == '0) begin
            case (ty)
                TY_LSL: req_o.kind = K_PASS;
                TY_LSR: req_o.amt  = RAMT_W'(OPW);
                TY_ASR: req_o.amt  = RAMT_W'(OPW);
                default: begin
                    req_o.kind = K_RRX;
                    req_o.amt  = RAMT_W'(1);
                end
            endcase
        end
    end

    // R3: a register-held amount is never replaced by the field amount
    always_comb begin
        if (rsel) p_rs_amount_r3: assert (req_o.amt == ramt)
            else $error("p_rs_amount_r3");
    end
endmodule

// File: rtl/op2_imm_rot.sv
`timescale 1ns/1ps
module op2_imm_rot
    import op2_pkg::*;
(
    input  logic [IMM_W-1:0] imm_i,
    input  logic [ROT_W-1:0] rot_i,
    input  logic             cin_i,
    output shift_res_t       res_o
);
    logic [OPW-1:0]   ext;
    logic [OPW-1:0]   rotd;
    logic [IDX_W-1:0] step;

    assign ext  = OPW'(imm_i);
    assign step = IDX_W'({rot_i, 1'b0});

    // One source mux per output bit; the index wraps in IDX_W bits.
    for (genvar i = 0; i < OPW; i++) begin : g_bit
        logic [IDX_W-1:0] src;
        assign src     = IDX_W'(i) + step;
        assign rotd[i] = ext[src];
    end

    assign res_o.value = rotd;
    assign res_o.carry = (rot_i == '0) ? cin_i : rotd[OPW-1];

    // R1: rotation neither creates nor loses set bits
    always_comb begin
        p_imm_ones_r1: assert ($countones(res_o.value) == $countones(imm_i))
            else $error("p_imm_ones_r1");
    end
endmodule

// File: rtl/op2_shift_core.sv
`timescale 1ns/1ps
module op2_shift_core
    import op2_pkg::*;
(
    input  shift_req_t     req_i,
    input  logic [OPW-1:0] val_i,
    input  logic           cin_i,
    output shift_res_t     res_o
);
    logic [OPW:0]          ext_l;
    logic [OPW:0]          ext_r;
    logic signed [OPW:0]   ext_a;
    logic [2*OPW-1:0]      dbl;

    // One extra bit beside the word catches the last bit shifted out.
    always_comb begin
        ext_l = {1'b0, val_i} << req_i.amt;
        ext_r = {val_i, 1'b0} >> req_i.amt;
        ext_a = $signed({val_i, 1'b0}) >>> req_i.amt;
        dbl   = {val_i, val_i} >> req_i.amt[IDX_W-1:0];
        case (req_i.kind)
            K_LSL: begin
                res_o.value = ext_l[OPW-1:0];
                res_o.carry = ext_l[OPW];
            end
            K_LSR: begin
                res_o.value = ext_r[OPW:1];
                res_o.carry = ext_r[0];
            end
            K_ASR: begin
                res_o.value = ext_a[OPW:1];
                res_o.carry = ext_a[0];
            end
            K_ROR: begin
                res_o.value = dbl[OPW-1:0];
                res_o.carry = dbl[OPW-1];
            end
            K_RRX: begin
                res_o.value = {cin_i, val_i[OPW-1:1]};
                res_o.carry = val_i[0];
            end
            default: begin
                res_o.value = val_i;
                res_o.carry = cin_i;
            end
        endcase
    end

    // R10: left shift past the word leaves nothing
    always_comb begin
        if (req_i.kind == K_LSL && req_i.amt > RAMT_W'(OPW))
            p_lsl_far_r10: assert (res_o.value == '0 && !res_o.carry)
                else $error("p_lsl_far_r10");
    end

    // R10: arithmetic shift of 32 or more saturates to the sign
    always_comb begin
        if (req_i.kind == K_ASR && req_i.amt >= RAMT_W'(OPW))
            p_asr_sat_r10: assert (res_o.value == {OPW{val_i[OPW-1]}} && res_o.carry == val_i[OPW-1])
                else $error("p_asr_sat_r10");
    end

    // R8: rotation keeps the number of set bits
    always_comb begin
        if (req_i.kind == K_ROR)
            p_ror_ones_r8: assert ($countones(res_o.value) == $countones(val_i))
                else $error("p_ror_ones_r8");
    end

    // R7: rotate through carry keeps set bits across value plus flag
    always_comb begin
        if (req_i.kind == K_RRX)
            p_rrx_ones_r7: assert ($countones({res_o.value, res_o.carry}) == $countones({val_i, cin_i}))
                else $error("p_rrx_ones_r7");
    end
endmodule

// File: rtl/op2_shifter.sv
`timescale 1ns/1ps
module op2_shifter
    import op2_pkg::*;
(
    input  logic [FLD_W-1:0] op2_field,
    input  logic             imm_sel,
    input  logic [OPW-1:0]   rm_val,
    input  logic [OPW-1:0]   rs_val,
    input  logic             carry_in,
    output logic [OPW-1:0]   operand_out,
    output logic             carry_out
);
    shift_req_t req;
    shift_res_t imm_res;
    shift_res_t reg_res;
    shift_res_t sel_res;

    op2_decode u_decode (
        .field_i (op2_field),
        .rs_i    (rs_val),
        .req_o   (req)
    );

    op2_imm_rot u_imm (
        .imm_i (op2_field[IMM_W-1:0]),
        .rot_i (op2_field[FLD_W-1:IMM_W]),
        .cin_i (carry_in),
        .res_o (imm_res)
    );

    op2_shift_core u_core (
        .req_i (req),
        .val_i (rm_val),
        .cin_i (carry_in),
        .res_o (reg_res)
    );

    assign sel_res     = imm_sel ? imm_res : reg_res;
    assign operand_out = sel_res.value;
    assign carry_out   = sel_res.carry;

    // R2: unrotated immediate keeps the flag, rotated one reports bit 31
    always_comb begin
        if (imm_sel && op2_field[FLD_W-1:IMM_W] == '0)
            p_imm_keep_r2: assert (carry_out == carry_in && operand_out == OPW'(op2_field[IMM_W-1:0]))
                else $error("p_imm_keep_r2");
        if (imm_sel && op2_field[FLD_W-1:IMM_W] != '0)
            p_imm_msb_r2: assert (carry_out == operand_out[OPW-1])
                else $error("p_imm_msb_r2");
    end

    // R9: register amount zero is transparent
    always_comb begin
        if (!imm_sel && op2_field[RSEL_BIT] && rs_val[RAMT_W-1:0] == '0)
            p_zero_amt_r9: assert (operand_out == rm_val && carry_out == carry_in)
                else $error("p_zero_amt_r9");
    end
endmodule

// File: tb/test_op2_shifter.sv
`timescale 1ns/1ps
module test_op2_shifter;
    logic        clk = 1'b0;
    logic [11:0] op2_field = '0;
    logic        imm_sel = 1'b0;
    logic [31:0] rm_val = '0;
    logic [31:0] rs_val = '0;
    logic        carry_in = 1'b0;
    logic [31:0] operand_out;
    logic        carry_out;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    op2_shifter i_op2_shifter (
        .op2_field   (op2_field),
        .imm_sel     (imm_sel),
        .rm_val      (rm_val),
        .rs_val      (rs_val),
        .carry_in    (carry_in),
        .operand_out (operand_out),
        .carry_out   (carry_out)
    );

    // Bit-serial model: kind 0 lsl, 1 lsr, 2 asr, 3 ror, 4 rotate through carry.
    // Returns {carry, value}.
    function automatic logic [32:0] ref_op(input int kind, input int n,
                                           input logic [31:0] v, input logic c);
        logic [31:0] x;
        logic        co;
        x  = v;
        co = c;
        if (kind == 4) return {v[0], c, v[31:1]};
        for (int k = 0; k < n; k++) begin
            case (kind)
                0: begin co = x[31]; x = {x[30:0], 1'b0}; end
                1: begin co = x[0];  x = {1'b0, x[31:1]}; end
                2: begin co = x[0];  x = {x[31], x[31:1]}; end
                default: begin co = x[0]; x = {x[0], x[31:1]}; end
            endcase
        end
        return {co, x};
    endfunction

    function automatic logic [31:0] pat(input int p);
        case (p)
            0: return 32'h8000_0001;
            1: return 32'h7FFF_FFFE;
            2: return 32'hA5A5_3C0F;
            3: return 32'hFFFF_FFFF;
            4: return 32'h0000_0000;
            5: return 32'h1234_5678;
            6: return 32'hF000_0000;
            default: return 32'h8000_0000;
        endcase
    endfunction

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic apply(input logic [11:0] f, input logic is,
                         input logic [31:0] rm, input logic [31:0] rs, input logic c);
        @(posedge clk);
        op2_field = f;
        imm_sel   = is;
        rm_val    = rm;
        rs_val    = rs;
        carry_in  = c;
    endtask

    task automatic check(input string tag, input logic [32:0] exp);
        @(negedge clk);
        n_chk++;
        if ({carry_out, operand_out} !== exp) begin
            n_bad++;
            $display("FAIL %s: field=%h imm=%b rm=%h rs=%h cin=%b got value=%h carry=%b expected value=%h carry=%b",
                     tag, op2_field, imm_sel, rm_val, rs_val, carry_in,
                     operand_out, carry_out, exp[31:0], exp[32]);
        end
    endtask

    initial begin
        logic [32:0] e;
        // All-zero inputs: left shift by zero of zero, carry clear (R4)
        apply(12'h000, 1'b0, 32'h0, 32'h0, 1'b0);
        check("R4 idle", 33'h0);

        // R1 worked examples
        apply(12'hD40, 1'b1, 32'hDEAD_BEEF, 32'h1, 1'b0);
        check("R1 0x40 rot26", {1'b0, 32'h0000_1000});
        apply(12'h8FF, 1'b1, 32'h0, 32'h0, 1'b1);
        check("R1 0xFF rot16", {1'b0, 32'h00FF_0000});
        apply(12'h4FF, 1'b1, 32'h0, 32'h0, 1'b0);
        check("R1 0xFF rot8", {1'b1, 32'hFF00_0000});

        // Immediate sweep with busy register inputs (R1, R2)
        for (int f = 0; f < 4096; f++) begin
            for (int c = 0; c < 2; c++) begin
                e = ref_op(3, 2 * (f >> 8), {24'h0, 8'(f)}, 1'b0);
                e[32] = ((f >> 8) == 0) ? 1'(c) : e[31];
                apply(12'(f), 1'b1, pat(f % 8), ~pat((f + 3) % 8), 1'(c));
                check("R1/R2 imm", e);
            end
        end

        // Field-held amounts, all types and amounts (R3..R8)
        for (int p = 0; p < 8; p++) begin
            for (int t = 0; t < 4; t++) begin
                for (int a = 0; a < 32; a++) begin
                    for (int c = 0; c < 2; c++) begin
                        string tag;
                        if (t == 0) begin
                            e = ref_op(0, a, pat(p), 1'(c));
                            tag = "R3/R4 field";
                        end else if (t < 3) begin
                            e = ref_op(t, (a == 0) ? 32 : a, pat(p), 1'(c));
                            tag = (a == 0) ? "R6 field" : "R5 field";
                        end else begin
                            e = ref_op((a == 0) ? 4 : 3, a, pat(p), 1'(c));
                            tag = (a == 0) ? "R7 field" : "R8 field";
                        end
                        apply({5'(a), 2'(t), 1'b0, 4'(p) ^ 4'hA}, 1'b0, pat(p),
                              32'(p) * 32'h9E37_79B9, 1'(c));
                        check(tag, e);
                    end
                end
            end
        end

        // Register-held amounts 0..255 with junk in unused bits (R3, R9..R11)
        for (int p = 0; p < 8; p++) begin
            for (int t = 0; t < 4; t++) begin
                for (int a = 0; a < 256; a++) begin
                    for (int c = 0; c < 2; c++) begin
                        string tag;
                        logic [31:0] junk;
                        junk = 32'(p + 1) * 32'h9E37_79B9;
                        e = ref_op(t, a, pat(p), 1'(c));
                        if (a == 0)                 tag = "R3/R9 reg";
                        else if (a >= 32 && t != 3) tag = "R3/R10 reg";
                        else if (a >= 32)           tag = "R3/R11 reg";
                        else if (t == 0)            tag = "R3/R4 reg";
                        else if (t == 3)            tag = "R3/R8 reg";
                        else                        tag = "R3/R5 reg";
                        apply({4'(p), 1'(p), 2'(t), 1'b1, ~4'(p)}, 1'b0, pat(p),
                              {junk[31:8], 8'(a)}, 1'(c));
                        check(tag, e);
                    end
                end
            end
        end

        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no finish, expected finish before 100000 cycles");
            report();
        end
    end
endmodule